// File: doc/BRIEF.md
# Single-channel DMA mover with source rewind

This block is one DMA channel. Each transfer reads one unit (8, 16 or 32 bits) from a source address and writes it unchanged to a fixed destination address. The source address advances by the unit size after each transfer. A down-counter holds the number of transfers left. When it reaches zero, the channel raises its end flag and stops requesting the bus.

With rewind mode on, a hidden two-bit phase counter counts completed transfers. After every fourth one, the source address goes back to its programmed start. A four-element buffer is then played out again and again for as long as the count lasts. Several events clear the phase counter: a non-maskable interrupt, standby, clearing either enable bit, the end flag, and reset. The programmed start, the current source address, the destination and the count survive everything except reset. The channel therefore reports a restart that does not first rewrite all three of those registers.

Software programs the channel through a small write-only register port. Four registers are selected by `cfg_addr`: 0 = source start, 1 = destination, 2 = count, 3 = control. The control bits are: bit 0 channel enable, bit 1 global enable, bits 3:2 size code (0 byte, 1 half, 2 word, 3 illegal), bit 4 rewind enable.

Top module: `dma_reload_chan`

## Requirements
- R1: Each transfer is one read from the source address, followed by a write of the data that read returned to the destination address. A request is held, with address and direction steady, until `mem_ack`. The next read is issued only after the write is acknowledged.
- R2: With rewind off, the source address advances by 1, 2 or 4 for size codes 0, 1 and 2. `mem_size` carries the size code. Every write goes to the programmed destination.
- R3: With rewind on, the source sequence is start, start+s, start+2s, start+3s, and then start again, repeating every four completed transfers.
- R4: The count drops by one at the end of every transfer, in either mode. When it reaches zero, `xfer_end` rises and no further request is made. Any control write clears `xfer_end`.
- R5: A control write that asks for size code 3, or for rewind while the last value written to the count register is not a multiple of four, sets `cfg_err` and leaves the channel disabled. The next acceptable control write clears `cfg_err`.
- R6: The phase counter is cleared by an NMI, by standby, by either enable bit being low, and by the end flag. A transfer whose write is acknowledged in the same cycle as an NMI still counts and still moves the source address, but the phase restarts from zero.
- R7: An NMI or standby lets an outstanding access finish, issues no further access, and clears the global enable. The channel stays idle until the next enabling control write.
- R8: When a running channel is stopped by anything other than the end flag, and is then re-enabled before the source, destination and count registers have all been rewritten, `restart_err` is set. The channel then runs on the retained current source address, destination and remaining count, with the phase at zero.
- R9: Rewriting all three registers before re-enabling, or re-enabling after a normal end, leaves `restart_err` at 0. The transfers then begin at the newly written start.
- R10: After reset there is no request, and `xfer_end`, `cfg_err` and `restart_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | AW | Register write data |
| nmi | input | 1 | Non-maskable interrupt pulse |
| standby | input | 1 | Standby request level |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Access address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with ack |
| mem_ack | input | 1 | Access complete |
| xfer_end | output | 1 | Transfer-end flag |
| cfg_err | output | 1 | Illegal configuration reported |
| restart_err | output | 1 | Restart without reprogramming reported |

## Verification
A transfer can complete in the same cycle as an NMI clears the phase counter. The bench provokes this by pulsing `nmi` exactly when it acknowledges the second write of a rewind run. It then expects three things: that transfer is counted, the source still advances, and after an unreprogrammed restart the rewind comes four transfers later, not at the original boundary. The total number of writes up to `xfer_end` must equal the programmed count. A second overlap puts standby over a pending read, which must finish without its write.

// File: rtl/dma_reload_pkg.sv
package dma_reload_pkg;

   typedef enum logic [1:0] {
      XS_BYTE = 2'd0,
      XS_HALF = 2'd1,
      XS_WORD = 2'd2,
      XS_BAD  = 2'd3
   } xsize_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2
   } xstate_e;

   localparam logic [1:0] RA_SRC = 2'd0;
   localparam logic [1:0] RA_DST = 2'd1;
   localparam logic [1:0] RA_CNT = 2'd2;
   localparam logic [1:0] RA_CTL = 2'd3;

   localparam int CB_CE = 0;
   localparam int CB_GE = 1;
   localparam int CB_SZ = 2;
   localparam int CB_RL = 4;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
   import dma_reload_pkg::*;
#(
   parameter int unsigned AW = 32,
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [1:0]    cfg_addr,
   input  logic [AW-1:0] cfg_wdata,
   input  logic          abort_evt,
   input  logic          xfer_done,
   output logic          src_load,
   output logic [AW-1:0] dst_addr,
   output logic [CW-1:0] count,
   output logic          glob_en,
   output logic          chan_en,
   output logic          reload_on,
   output xsize_e        xsize,
   output logic          te_flag,
   output logic          cfg_err,
   output logic          restart_err
);

   localparam int unsigned NREG = 3;

   if (CW < 3 || CW > AW) begin : g_bad_cw
      $error("dma_cfg_regs: CW must lie between 3 and AW");
   end

   logic            wr_src, wr_dst, wr_cnt, wr_ctl;
   logic            w_ce, w_ge, w_rl, bad, start_ok;
   xsize_e          w_sz;
   logic            cnt_al_q, armed, te_set, sw_stop, stop_evt;
   logic            stale_q;
   logic [NREG-1:0] mask_q;

   assign wr_src   = cfg_we && (cfg_addr == RA_SRC);
   assign wr_dst   = cfg_we && (cfg_addr == RA_DST);
   assign wr_cnt   = cfg_we && (cfg_addr == RA_CNT);
   assign wr_ctl   = cfg_we && (cfg_addr == RA_CTL);
   assign src_load = wr_src;

   assign w_ce     = cfg_wdata[CB_CE];
   assign w_ge     = cfg_wdata[CB_GE];
   assign w_rl     = cfg_wdata[CB_RL];
   assign w_sz     = xsize_e'(cfg_wdata[CB_SZ +: 2]);
   assign bad      = (w_sz == XS_BAD) || (w_rl && !cnt_al_q);
   assign start_ok = w_ce && w_ge && !bad;

   assign armed    = glob_en && chan_en && !te_flag;
   assign te_set   = xfer_done && (count == CW'(1));
   assign sw_stop  = wr_ctl && armed && !start_ok;
   assign stop_evt = armed && (abort_evt || sw_stop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dst_addr    <= '0;
         count       <= '0;
         cnt_al_q    <= 1'b1;
         glob_en     <= 1'b0;
         chan_en     <= 1'b0;
         reload_on   <= 1'b0;
         xsize       <= XS_BYTE;
         te_flag     <= 1'b0;
         cfg_err     <= 1'b0;
         restart_err <= 1'b0;
         stale_q     <= 1'b0;
         mask_q      <= '0;
      end else begin
         if (wr_dst) dst_addr <= cfg_wdata;
         if (wr_cnt) begin
            count    <= cfg_wdata[CW-1:0];
            cnt_al_q <= (cfg_wdata[1:0] == 2'b00);
         end else if (xfer_done) begin
            count <= count - CW'(1);
         end
         if (wr_ctl) begin
            chan_en   <= w_ce && !bad;
            reload_on <= w_rl;
            xsize     <= w_sz;
            cfg_err   <= bad;
         end
         if (abort_evt)   glob_en <= 1'b0;
         else if (wr_ctl) glob_en <= w_ge;
         if (te_set)      te_flag <= 1'b1;
         else if (wr_ctl) te_flag <= 1'b0;
         if (stop_evt) begin
            stale_q <= 1'b1;
            mask_q  <= '0;
         end else begin
            mask_q <= mask_q | {wr_cnt, wr_dst, wr_src};
            if (wr_ctl && start_ok) begin
               restart_err <= stale_q && (mask_q != {NREG{1'b1}});
               stale_q     <= 1'b0;
            end
         end
      end
   end

   p_abort_drops_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      abort_evt |=> !glob_en);

   p_bad_cfg_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !chan_en);

endmodule

// File: rtl/dma_src_addr.sv
module dma_src_addr
   import dma_reload_pkg::*;
#(
   parameter int unsigned AW          = 32,
   parameter bit          RELOAD_IMPL = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          done,
   input  logic          reload_on,
   input  xsize_e        xsize,
   input  logic          clr,
   output logic [AW-1:0] cur
);

   if (AW < 8) begin : g_bad_aw
      $error("dma_src_addr: AW must be at least 8");
   end

   logic [1:0]    szb;
   logic [AW-1:0] step;

   assign szb  = xsize;
   assign step = AW'(1) << szb;

   if (RELOAD_IMPL) begin : g_rewind
      logic [AW-1:0] base_q;
      logic [1:0]    ph_q;
      logic          wrap;

      assign wrap = reload_on && (ph_q == 2'd3);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q <= '0;
            ph_q   <= '0;
            cur    <= '0;
         end else begin
            if (load) base_q <= load_val;
            if (clr)                     ph_q <= '0;
            else if (done && reload_on)  ph_q <= ph_q + 2'd1;
            if (load)      cur <= load_val;
            else if (done) cur <= wrap ? base_q : cur + step;
         end
      end

      p_rewind_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (done && wrap && !load) |=> (cur == $past(base_q)));

      p_phase_rests_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (clr && !reload_on) |=> (ph_q == 2'd0));
   end else begin : g_linear
      logic unused_in;
      assign unused_in = ^{clr, reload_on};

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    cur <= '0;
         else if (load) cur <= load_val;
         else if (done) cur <= cur + step;
      end
   end

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
   import dma_reload_pkg::*;
#(
   parameter int unsigned AW = 32,
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          cnt_nz,
   input  logic          cnt_gt1,
   input  logic [AW-1:0] src_addr,
   input  logic [AW-1:0] dst_addr,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          xfer_done
);

   xstate_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:  if (go && cnt_nz) st_d = ST_READ;
         ST_READ:  if (mem_ack) st_d = go ? ST_WRITE : ST_IDLE;
         ST_WRITE: if (mem_ack) st_d = (go && cnt_gt1) ? ST_READ : ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         mem_wdata <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_READ && mem_ack) mem_wdata <= mem_rdata;
      end
   end

   assign mem_req   = (st_q != ST_IDLE);
   assign mem_we    = (st_q == ST_WRITE);
   assign mem_addr  = mem_we ? dst_addr : src_addr;
   assign xfer_done = mem_we && mem_ack;

   p_hold_access_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

   p_read_then_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_ack && go) |=> (mem_req && mem_we));

   p_write_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_ack) |=> (mem_wdata == $past(mem_rdata)));

endmodule

// File: rtl/dma_reload_chan.sv
module dma_reload_chan
   import dma_reload_pkg::*;
#(
   parameter int unsigned AW          = 32,
   parameter int unsigned DW          = 32,
   parameter int unsigned CW          = 16,
   parameter bit          RELOAD_IMPL = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [1:0]    cfg_addr,
   input  logic [AW-1:0] cfg_wdata,
   input  logic          nmi,
   input  logic          standby,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [1:0]    mem_size,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_ack,
   output logic          xfer_end,
   output logic          cfg_err,
   output logic          restart_err
);

   if (DW % 8 != 0 || DW < 32) begin : g_bad_dw
      $error("dma_reload_chan: DW must be a multiple of 8 and at least 32");
   end

   logic          abort_evt, xfer_done, src_load;
   logic          glob_en, chan_en, reload_on, te_flag, go, clr;
   logic [AW-1:0] dst_addr, src_cur;
   logic [CW-1:0] count;
   xsize_e        xsize;

   assign abort_evt = nmi || standby;
   assign go        = glob_en && chan_en && !te_flag && !abort_evt;
   assign clr       = abort_evt || !glob_en || !chan_en || te_flag;
   assign mem_size  = xsize;
   assign xfer_end  = te_flag;

   dma_cfg_regs #(.AW(AW), .CW(CW)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .abort_evt  (abort_evt),
      .xfer_done  (xfer_done),
      .src_load   (src_load),
      .dst_addr   (dst_addr),
      .count      (count),
      .glob_en    (glob_en),
      .chan_en    (chan_en),
      .reload_on  (reload_on),
      .xsize      (xsize),
      .te_flag    (te_flag),
      .cfg_err    (cfg_err),
      .restart_err(restart_err)
   );

   dma_src_addr #(.AW(AW), .RELOAD_IMPL(RELOAD_IMPL)) u_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (src_load),
      .load_val  (cfg_wdata),
      .done      (xfer_done),
      .reload_on (reload_on),
      .xsize     (xsize),
      .clr       (clr),
      .cur       (src_cur)
   );

   dma_xfer_fsm #(.AW(AW), .DW(DW)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .cnt_nz    (count != '0),
      .cnt_gt1   (count > CW'(1)),
      .src_addr  (src_cur),
      .dst_addr  (dst_addr),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .xfer_done (xfer_done)
   );

   p_end_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_end |-> !mem_req);

   p_standby_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (standby && !mem_req) |=> !mem_req);

endmodule

// File: tb/dma_reload_chan_test.sv
module dma_reload_chan_test;

   logic        clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        nmi = 1'b0, standby = 1'b0;
   logic        mem_req, mem_we, xfer_end, cfg_err, restart_err;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;
   logic [1:0]  mem_size;

   int checks = 0, errors = 0;
   logic [31:0] m_cur, m_base, m_dst, last_ra;
   int          m_cnt = 0, m_rc = 0, m_size = 0;
   bit          m_rl = 1'b0, exp_wr = 1'b0, ack_ok = 1'b1;
   int          n_rd = 0, n_wr = 0, nmi_at = -1;

   always #4 clk = ~clk;

   dma_reload_chan uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .nmi(nmi), .standby(standby),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ack(mem_ack), .xfer_end(xfer_end), .cfg_err(cfg_err),
      .restart_err(restart_err)
   );

   function automatic logic [31:0] hashf(input logic [31:0] a);
      return {a[15:0], ~a[31:16]} ^ 32'h5A3C_9E71;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic model_done(input bit aborted);
      logic [31:0] step;
      step = 32'd1 << m_size;
      m_cnt--;
      if (m_rl) begin
         if (m_rc == 3) begin m_cur = m_base; m_rc = 0; end
         else begin m_cur = m_cur + step; m_rc++; end
      end else begin
         m_cur = m_cur + step;
      end
      if (aborted) m_rc = 0;
   endtask

   task automatic tick();
      @(negedge clk);
      nmi = 1'b0;
      mem_ack = 1'b0;
      if (rst_n && mem_req && ack_ok && ($urandom % 4 != 0)) begin
         mem_ack = 1'b1;
         mem_rdata = hashf(mem_addr);
         chk(mem_size == 2'(m_size), "R2 size", 32'(mem_size), 32'(m_size));
         if (!mem_we) begin
            chk(!exp_wr, "R1 read order", 32'(exp_wr), 0);
            chk(mem_addr == m_cur, m_rl ? "R3 source" : "R2 source", mem_addr, m_cur);
            last_ra = mem_addr;
            exp_wr = 1'b1;
            n_rd++;
         end else begin
            chk(exp_wr, "R1 write order", 32'(exp_wr), 1);
            chk(mem_addr == m_dst, "R2 destination", mem_addr, m_dst);
            chk(mem_wdata == hashf(last_ra), "R1 data", mem_wdata, hashf(last_ra));
            exp_wr = 1'b0;
            n_wr++;
            if (nmi_at == n_wr) nmi = 1'b1;
            model_done(nmi_at == n_wr);
         end
      end
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
      cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic prog(input logic [31:0] s, input logic [31:0] d, input int c);
      wr_reg(2'd0, s); wr_reg(2'd1, d); wr_reg(2'd2, 32'(c));
      m_cur = s; m_base = s; m_dst = d; m_cnt = c;
   endtask

   task automatic start(input int sz, input bit rl);
      m_size = sz; m_rl = rl; m_rc = 0;
      wr_reg(2'd3, 32'h3 | (32'(sz) << 2) | (32'(rl) << 4));
   endtask

   task automatic quiet();
      int idle = 0;
      for (int i = 0; i < 3000 && idle < 5; i++) begin
         tick();
         idle = mem_req ? 0 : idle + 1;
      end
   endtask

   initial begin
      #(8 * 150000);
      $display("FAIL watchdog: actual hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
      $finish;
   end

   initial begin
      int w0, r0, c;
      void'($urandom(32'd20240611));
      repeat (3) tick();
      // R10 reset state
      chk(!mem_req, "R10 req", 32'(mem_req), 0);
      chk(!xfer_end, "R10 end", 32'(xfer_end), 0);
      chk(!cfg_err && !restart_err, "R10 errs", 32'({cfg_err, restart_err}), 0);
      rst_n = 1'b1;
      tick();

      // R2 / R4 linear runs in each size
      for (int sz = 0; sz < 3; sz++) begin
         w0 = n_wr;
         prog(32'h0001_0000 + 32'(sz) * 32'h100, 32'h0002_0000 + 32'(sz), 5);
         start(sz, 1'b0);
         quiet();
         chk(xfer_end, "R4 end flag", 32'(xfer_end), 1);
         chk(n_wr - w0 == 5, "R4 count", 32'(n_wr - w0), 5);
         chk(!mem_req, "R4 quiet", 32'(mem_req), 0);
      end

      // R3 rewind in half size over two buffers
      w0 = n_wr;
      prog(32'h0000_3000, 32'h0000_7000, 8);
      start(1, 1'b1);
      quiet();
      chk(xfer_end && n_wr - w0 == 8, "R3 rewind run", 32'(n_wr - w0), 8);

      // R5 illegal configurations
      w0 = n_wr;
      prog(32'h100, 32'h200, 6);
      start(1, 1'b1);
      chk(cfg_err, "R5 count not multiple of four", 32'(cfg_err), 1);
      quiet();
      chk(n_wr == w0 && !mem_req, "R5 stays idle", 32'(n_wr - w0), 0);
      prog(32'h100, 32'h200, 4);
      start(3, 1'b0);
      chk(cfg_err, "R5 size code 3", 32'(cfg_err), 1);
      quiet();
      chk(n_wr == w0, "R5 size 3 idle", 32'(n_wr - w0), 0);

      // R6 / R7 / R8 NMI in the same cycle as a write ack
      w0 = n_wr;
      prog(32'h0000_1000, 32'h0000_2000, 8);
      start(1, 1'b1);
      chk(!cfg_err, "R5 cleared", 32'(cfg_err), 0);
      nmi_at = n_wr + 2;
      quiet();
      nmi_at = -1;
      chk(n_wr - w0 == 2, "R7 no access after nmi", 32'(n_wr - w0), 2);
      chk(!xfer_end, "R6 not ended", 32'(xfer_end), 0);
      repeat (5) tick();
      chk(!mem_req, "R7 global enable dropped", 32'(mem_req), 0);
      start(1, 1'b1);
      chk(restart_err, "R8 restart without reprogram", 32'(restart_err), 1);
      quiet();
      chk(xfer_end, "R6 end after restart", 32'(xfer_end), 1);
      chk(n_wr - w0 == 8, "R6 aborted transfer counted", 32'(n_wr - w0), 8);

      // R7 / R8 standby over a pending read
      w0 = n_wr; r0 = n_rd;
      prog(32'h0000_4000, 32'h0000_5000, 8);
      ack_ok = 1'b0;
      start(2, 1'b1);
      for (int i = 0; i < 5 && !mem_req; i++) tick();
      standby = 1'b1;
      tick(); tick();
      ack_ok = 1'b1;
      quiet();
      chk(n_rd - r0 == 1, "R7 read finishes", 32'(n_rd - r0), 1);
      chk(n_wr == w0, "R7 no write after standby", 32'(n_wr - w0), 0);
      exp_wr = 1'b0;
      standby = 1'b0;
      repeat (6) tick();
      chk(!mem_req, "R7 idle after standby", 32'(mem_req), 0);
      wr_reg(2'd0, 32'h0000_6000);
      m_cur = 32'h0000_6000; m_base = 32'h0000_6000;
      start(2, 1'b1);
      chk(restart_err, "R8 partial reprogram", 32'(restart_err), 1);
      quiet();
      chk(xfer_end && n_wr - w0 == 8, "R8 retained count", 32'(n_wr - w0), 8);

      // R9 full reprogram after an abort
      prog(32'h0000_8000, 32'h0000_9000, 4);
      start(0, 1'b1);
      nmi_at = n_wr + 1;
      quiet();
      nmi_at = -1;
      w0 = n_wr;
      prog(32'h0000_A000, 32'h0000_B000, 8);
      start(0, 1'b1);
      chk(!restart_err, "R9 full reprogram", 32'(restart_err), 0);
      quiet();
      chk(xfer_end && n_wr - w0 == 8, "R9 run from new start", 32'(n_wr - w0), 8);

      // R4 / R9 random runs, restarting after normal end
      for (int k = 0; k < 8; k++) begin
         int sz; bit rl;
         sz = $urandom % 3;
         rl = 1'($urandom % 2);
         c = rl ? 4 * (1 + $urandom % 3) : 1 + $urandom % 9;
         w0 = n_wr;
         prog($urandom & 32'hFFFF_FF00, $urandom, c);
         start(sz, rl);
         chk(!restart_err && !cfg_err, "R9 clean restart", 32'({cfg_err, restart_err}), 0);
         quiet();
         chk(xfer_end, "R4 random end", 32'(xfer_end), 1);
         chk(n_wr - w0 == c, "R4 random count", 32'(n_wr - w0), 32'(c));
      end

      wr_reg(2'd3, 32'h0);
      chk(!xfer_end, "R4 end flag cleared", 32'(xfer_end), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule